// File: doc/BRIEF.md
# Half-Rate Frame Interrupt Controller

This block sits between a CPU write port and the interrupt input of that CPU. It has two parts. The first is a bit-addressable control latch that occupies a window of eight consecutive write addresses. A write to one of these addresses stores data bit 0 into a single latch slot. The low three address bits choose the slot. The latched slots supply the interrupt enable, two coin counter drives, and horizontal and vertical screen flip.

The second part is a frame interrupt generator. It samples the vertical-blank signal into the system clock domain and flips an internal phase bit on each rising edge of that signal. The CPU interrupt line is held high while the phase bit is 1 and the enable slot is 1, so the CPU sees one level interrupt every second frame. Software clears the interrupt by writing 0 to the enable slot, and this write also serves as the acknowledge.

Top module: `frame_irq_ctrl`

## Requirements
- R1: A cycle with `rst` high clears all eight latch slots and the frame phase bit. After reset, `irq`, `irq_en`, `coin_cnt1`, `coin_cnt2`, `flip_x` and `flip_y` all read 0.
- R2: When `wr_en` is high at a rising clock edge and `addr` equals BASE+k (BASE = 0x8030, k = 0..7), latch slot k takes the value of `wdata0` and the other seven slots keep their values. The new value shows on the outputs from the next cycle on.
- R3: The slot-to-output mapping is fixed: slot 0 drives `irq_en`, slot 1 drives `coin_cnt2`, slot 2 drives `coin_cnt1`, slot 4 drives `flip_x` and slot 5 drives `flip_y`. Slots 3, 6 and 7 store data but no port shows them, so writing them changes no output.
- R4: A write is ignored when `wr_en` is low. It is also ignored when the address lies outside 0x8030–0x8037, including addresses whose low three bits match but whose upper bits differ. Either way, no output changes.
- R5: `vblank` is registered twice in the clock domain. Each 0-to-1 transition of `vblank` inverts the phase bit exactly once, no matter how long `vblank` stays high. The inversion happens at the second rising clock edge after `vblank` rises.
- R6: `irq` is high exactly when both the phase bit and `irq_en` are 1. With the enable held at 1 after reset, `irq` is high after the 1st, 3rd, 5th and later odd vblank edges, and low after the even ones.
- R7: Writing 0 to slot 0 drops `irq` in the next cycle and leaves the phase bit unchanged. If slot 0 is set back to 1 while the phase is still 1, `irq` rises again.
- R8: If an enable write and a phase inversion take effect on the same clock edge, both take effect. `irq` then equals the new phase ANDed with the new enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU write address |
| wdata0 | input | 1 | CPU data bit 0 |
| vblank | input | 1 | Vertical-blank level from the video timing, asynchronous |
| irq | output | 1 | Level interrupt request to the CPU |
| irq_en | output | 1 | Latch slot 0, interrupt enable |
| coin_cnt2 | output | 1 | Latch slot 1, second coin counter drive |
| coin_cnt1 | output | 1 | Latch slot 2, first coin counter drive |
| flip_x | output | 1 | Latch slot 4, horizontal flip |
| flip_y | output | 1 | Latch slot 5, vertical flip |

## Verification
A CPU write to the enable slot and a phase inversion caused by a vblank edge can land on the same clock edge. Each can change `irq`, in opposite or matching directions. The bench raises `vblank` one cycle before it issues an enable write, so both updates resolve on the same edge. It does this for each combination of old phase and new enable value. It then compares `irq` against the product of a phase and enable model that it keeps by counting vblank edges and tracking writes.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  localparam int unsigned SLOT_SEL_W = 3;

  // Slot numbers inside the control latch; the order is decoded by the top.
  typedef enum logic [SLOT_SEL_W-1:0] {
    SLOT_IRQ_EN = 3'd0,
    SLOT_COIN2  = 3'd1,
    SLOT_COIN1  = 3'd2,
    SLOT_SPARE3 = 3'd3,
    SLOT_FLIP_X = 3'd4,
    SLOT_FLIP_Y = 3'd5,
    SLOT_SPARE6 = 3'd6,
    SLOT_SPARE7 = 3'd7
  } slot_e;

endpackage

// File: rtl/ctl_bit_latch.sv
module ctl_bit_latch #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 3,
  parameter logic [ADDR_W-1:0] BASE = 16'h8030,
  localparam int unsigned NSLOT = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  output logic [NSLOT-1:0]  slot_q
);

  logic window_hit;
  logic [SEL_W-1:0] sel;

  assign window_hit = wr_en && (addr[ADDR_W-1:SEL_W] == BASE[ADDR_W-1:SEL_W]);
  assign sel        = addr[SEL_W-1:0];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[k] <= 1'b0;
      else if (window_hit && (sel == SEL_W'(k)))
        slot_q[k] <= wbit;
    end
  end

endmodule

// File: rtl/level_rise_sync.sv
module level_rise_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)
      sr <= '0;
    else
      sr <= {sr[STAGES-2:0], level_in};
  end

  assign rise = sr[STAGES-2] & ~sr[STAGES-1];

endmodule

// File: rtl/half_rate_irq.sv
module half_rate_irq (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic enable,
  output logic irq
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= 1'b0;
    else if (frame_tick)
      phase_q <= ~phase_q;
  end

  // Level request; enable comes straight from a latch flop.
  assign irq = phase_q & enable;

endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h8030,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata0,
  input  logic              vblank,
  output logic              irq,
  output logic              irq_en,
  output logic              coin_cnt2,
  output logic              coin_cnt1,
  output logic              flip_x,
  output logic              flip_y
);
  import frame_irq_pkg::*;

  localparam int unsigned NSLOT = 1 << SLOT_SEL_W;

  logic [NSLOT-1:0] slot_q;
  logic             vb_rise;
  logic             spare_unused;

  ctl_bit_latch #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SLOT_SEL_W),
    .BASE   (BASE)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wbit   (wdata0),
    .slot_q (slot_q)
  );

  level_rise_sync #(
    .STAGES (SYNC_STAGES)
  ) u_vb_sync (
    .clk      (clk),
    .rst      (rst),
    .level_in (vblank),
    .rise     (vb_rise)
  );

  half_rate_irq u_gen (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (vb_rise),
    .enable     (slot_q[SLOT_IRQ_EN]),
    .irq        (irq)
  );

  assign irq_en    = slot_q[SLOT_IRQ_EN];
  assign coin_cnt2 = slot_q[SLOT_COIN2];
  assign coin_cnt1 = slot_q[SLOT_COIN1];
  assign flip_x    = slot_q[SLOT_FLIP_X];
  assign flip_y    = slot_q[SLOT_FLIP_Y];

  assign spare_unused = &{1'b0, slot_q[SLOT_SPARE3], slot_q[SLOT_SPARE6], slot_q[SLOT_SPARE7]};

endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h8030
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wdata0,
  input logic              vblank,
  input logic              irq,
  input logic              irq_en,
  input logic              coin_cnt2,
  input logic              coin_cnt1,
  input logic              flip_x,
  input logic              flip_y
);

  logic vb_a, vb_b, in_window;
  logic [4:0] outs;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_a <= 1'b0;
      vb_b <= 1'b0;
    end else begin
      vb_a <= vblank;
      vb_b <= vb_a;
    end
  end

  assign in_window = wr_en && (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  assign outs = {irq_en, coin_cnt2, coin_cnt1, flip_x, flip_y};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (outs == 5'd0) && !irq);

  // R2
  enable_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == BASE) |=> (irq_en == $past(wdata0)));

  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> $stable(outs));

  // R5
  phase_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en && $past(irq_en) && (irq != $past(irq))) |-> $past(vb_a && !vb_b));

  // R7
  disable_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == BASE && !wdata0) |=> !irq);

endmodule

bind frame_irq_ctrl frame_irq_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_frame_irq_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata0(wdata0),
  .vblank(vblank), .irq(irq), .irq_en(irq_en), .coin_cnt2(coin_cnt2),
  .coin_cnt1(coin_cnt1), .flip_x(flip_x), .flip_y(flip_y)
);

// File: tb/test_frame_irq_ctrl.sv
module test_frame_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wdata0 = 1'b0;
  logic        vblank = 1'b0;
  logic irq, irq_en, coin_cnt2, coin_cnt1, flip_x, flip_y;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_slot = 8'h00;
  logic       m_phase = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  frame_irq_ctrl i_frame_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata0(wdata0),
    .vblank(vblank), .irq(irq), .irq_en(irq_en), .coin_cnt2(coin_cnt2),
    .coin_cnt1(coin_cnt1), .flip_x(flip_x), .flip_y(flip_y)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Compare every output against the model.
  task automatic check_all(string tag);
    check_bit({tag, " irq_en"},    irq_en,    m_slot[0]);
    check_bit({tag, " coin_cnt2"}, coin_cnt2, m_slot[1]);
    check_bit({tag, " coin_cnt1"}, coin_cnt1, m_slot[2]);
    check_bit({tag, " flip_x"},    flip_x,    m_slot[4]);
    check_bit({tag, " flip_y"},    flip_y,    m_slot[5]);
    check_bit({tag, " irq"},       irq,       m_phase & m_slot[0]);
  endtask

  // One-cycle write, driven after a falling edge; result visible at the next one.
  task automatic cpu_write(logic [15:0] a, logic d, logic strobe);
    wr_en = strobe; addr = a; wdata0 = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (strobe && a[15:3] == 13'h1006) m_slot[a[2:0]] = d;
  endtask

  task automatic frame(int high_cycles);
    vblank = 1'b1;
    repeat (high_cycles) @(negedge clk);
    vblank = 1'b0;
    m_phase = ~m_phase;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    // R2 R3: each slot set then cleared, all outputs compared each time
    for (int k = 0; k < 8; k++) begin
      cpu_write(16'h8030 + 16'(k), 1'b1, 1'b1);
      check_all($sformatf("R2 R3 set slot %0d", k));
    end
    for (int k = 7; k >= 0; k--) begin
      cpu_write(16'h8030 + 16'(k), 1'b0, 1'b1);
      check_all($sformatf("R2 R3 clear slot %0d", k));
    end
    // R3: alternating pattern across slots
    for (int k = 0; k < 8; k++) begin
      cpu_write(16'h8030 + 16'(k), 1'(k % 2), 1'b1);
      check_all($sformatf("R3 pattern slot %0d", k));
    end

    // R4: neighbouring addresses, aliased low bits, strobe low
    for (int k = 0; k < 8; k++) begin
      cpu_write(16'h8028 + 16'(k), ~m_slot[k], 1'b1);
      check_all($sformatf("R4 below window %0d", k));
      cpu_write(16'h8038 + 16'(k), ~m_slot[k], 1'b1);
      check_all($sformatf("R4 above window %0d", k));
      cpu_write(16'h0030 + 16'(k), ~m_slot[k], 1'b1);
      check_all($sformatf("R4 alias %0d", k));
      cpu_write(16'h8030 + 16'(k), ~m_slot[k], 1'b0);
      check_all($sformatf("R4 no strobe %0d", k));
    end

    // R5 R6: enable on, frames of varied length, irq on odd edges only
    cpu_write(16'h8030, 1'b1, 1'b1);
    for (int f = 1; f <= 8; f++) begin
      frame(f * 5);
      check_all($sformatf("R5 R6 frame %0d", f));
    end
    // R5: long held vblank toggles once
    frame(200);
    check_all("R5 held vblank");

    // R7: clear enable drops irq, phase kept, re-enable raises again
    if (!m_phase) frame(2);
    check_all("R7 pre");
    cpu_write(16'h8030, 1'b0, 1'b1);
    check_all("R7 disable drops irq");
    cpu_write(16'h8030, 1'b1, 1'b1);
    check_all("R7 re-enable raises irq");
    // R6: frames with enable off keep irq low
    cpu_write(16'h8030, 1'b0, 1'b1);
    frame(4);
    check_all("R6 disabled frame a");
    frame(4);
    check_all("R6 disabled frame b");

    // R8: enable write and phase flip on the same edge, all combinations
    for (int c = 0; c < 4; c++) begin
      cpu_write(16'h8030, 1'(c >> 1), 1'b1);
      vblank = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; addr = 16'h8030; wdata0 = ~1'(c >> 1);
      @(negedge clk);
      wr_en = 1'b0;
      m_slot[0] = ~1'(c >> 1);
      m_phase = ~m_phase;
      check_all($sformatf("R8 same edge case %0d", c));
      repeat (4) @(negedge clk);
      vblank = 1'b0;
      repeat (3) @(negedge clk);
      check_all($sformatf("R8 settle case %0d", c));
    end

    // R1: reset mid-run clears everything
    cpu_write(16'h8034, 1'b1, 1'b1);
    cpu_write(16'h8030, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_slot = 8'h00; m_phase = 1'b0;
    @(negedge clk);
    check_all("R1 second reset");
    cpu_write(16'h8030, 1'b1, 1'b1);
    frame(3);
    check_all("R1 phase cleared");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule